// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a parameterised chain of boundary-scan cells, one per bidirectional user pin. It sits between the core and the pads. A test access port controller drives a small set of global strobes into the chain: a data-register clock enable, a shift select, an update strobe and a two-bit mode. Serial test data enters at `sdi_i` and leaves at `sdo_o`.

Each cell holds three capture flops. They sample the core's output value, the core's active-low output enable and the pad input. Each cell also holds two update flops, one for the pad output value and one for the pad enable. There is no update flop on the input side, so the pad input always reaches the core unchanged.

The mode selects what drives the pads:
- Sampling lets core traffic pass through the cell.
- External test drives the pads from the update flops.
- Clamp also drives the pads from the update flops, and freezes the chain.
- High-impedance releases every pad, and also freezes the chain.

Top module: `bscan_chain`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) clears all capture flops to 0, sets every update value flop to 0, and sets every update enable flop to 1 (pad released).
- R2: With mode 2'b00 (sample/preload), `pad_out_o` equals `core_out_i` and `pad_oe_n_o` equals `core_oe_n_i` for every cell.
- R3: In modes 2'b00 and 2'b01, a rising `clk_i` edge with `clock_i`=1 and `shift_i`=0 loads each cell's capture flops as follows: the output flop from `core_out_i`, the enable flop from `core_oe_n_i`, and the input flop from `pad_in_i`.
- R4: In modes 2'b00 and 2'b01, a rising edge with `clock_i`=1 and `shift_i`=1 shifts the chain by one bit, and `sdo_o` shows the bit at the SDO end. The chain is 3N bits long. Chain position 3i holds cell i's input flop, 3i+1 its enable flop and 3i+2 its output flop. `sdi_i` enters position 0, and `sdo_o` shows position 3N-1. A bit entering at `sdi_i` therefore appears on `sdo_o` after 3N shifts.
- R5: In modes 2'b00 and 2'b01, a rising edge with `update_i`=1 copies each cell's output and enable capture flops into its update flops. The values copied are those the capture flops held before that edge.
- R6: With mode 2'b01 (external test), `pad_out_o` and `pad_oe_n_o` come from the update flops.
- R7: The pad enable is active low: a 0 in an update enable flop drives that cell's update value onto the pad.
- R8: With mode 2'b11 (high-impedance), every bit of `pad_oe_n_o` is 1.
- R9: With mode 2'b10 (clamp), `pad_out_o` and `pad_oe_n_o` come from the update flops.
- R10: In modes 2'b10 and 2'b11, `clock_i` and `update_i` have no effect: capture and update flops keep their values. This can be observed by returning to mode 2'b00 and shifting the chain out.
- R11: `core_in_o` equals `pad_in_i` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clock_i | input | 1 | Data-register clock enable (capture or shift) |
| shift_i | input | 1 | 1 selects shift, 0 selects capture |
| update_i | input | 1 | Update strobe |
| mode_i | input | 2 | 00 sample, 01 external test, 10 clamp, 11 high-impedance |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| core_out_i | input | N_PINS | Output value from core |
| core_oe_n_i | input | N_PINS | Active-low output enable from core |
| core_in_o | output | N_PINS | Pad input returned to core |
| pad_out_o | output | N_PINS | Value to pad driver |
| pad_oe_n_o | output | N_PINS | Active-low pad driver enable |
| pad_in_i | input | N_PINS | Value read from pad |

## Verification
The hardest behaviour to reach from the ports is the frozen chain in clamp and high-impedance modes. The flops are not visible at the ports in those modes, so a missed hold looks like correct behaviour. The stimulus first loads a known pattern and commits it to the update flops. It then toggles the clock and update strobes while in clamp and in high-impedance mode. Finally it returns to sample mode and shifts all 3N bits out, where the reference queue must still match bit for bit. A stretch of random strobes, modes and pin values then mixes capture, shift and update on the same edges.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    MODE_SAMPLE = 2'b00,
    MODE_EXTEST = 2'b01,
    MODE_CLAMP  = 2'b10,
    MODE_HIGHZ  = 2'b11
  } bscan_mode_e;
endpackage

// File: rtl/bscan_ctl.sv
module bscan_ctl
  import bscan_pkg::*;
(
  input  bscan_mode_e mode_i,
  input  logic        clock_i,
  input  logic        shift_i,
  input  logic        update_i,
  output logic        cap_en_o,
  output logic        shf_en_o,
  output logic        upd_en_o,
  output logic        use_upd_o,
  output logic        force_off_o
);
  logic scan_on;

  // chain only on the serial path in sample and extest
  assign scan_on     = (mode_i == MODE_SAMPLE) || (mode_i == MODE_EXTEST);
  assign cap_en_o    = scan_on && clock_i && !shift_i;
  assign shf_en_o    = scan_on && clock_i && shift_i;
  assign upd_en_o    = scan_on && update_i;
  assign use_upd_o   = (mode_i != MODE_SAMPLE);
  assign force_off_o = (mode_i == MODE_HIGHZ);
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shf_en_i,
  input  logic upd_en_i,
  input  logic use_upd_i,
  input  logic force_off_i,
  input  logic sdi_i,
  output logic sdo_o,
  input  logic core_out_i,
  input  logic core_oe_n_i,
  output logic core_in_o,
  output logic pad_out_o,
  output logic pad_oe_n_o,
  input  logic pad_in_i
);
  logic cap_in_q, cap_oe_q, cap_out_q;
  logic upd_out_q, upd_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_in_q  <= 1'b0;
      cap_oe_q  <= 1'b0;
      cap_out_q <= 1'b0;
    end else if (shf_en_i) begin
      cap_in_q  <= sdi_i;
      cap_oe_q  <= cap_in_q;
      cap_out_q <= cap_oe_q;
    end else if (cap_en_i) begin
      cap_in_q  <= pad_in_i;
      cap_oe_q  <= core_oe_n_i;
      cap_out_q <= core_out_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_out_q <= 1'b0;
      upd_oe_q  <= 1'b1;
    end else if (upd_en_i) begin
      upd_out_q <= cap_out_q;
      upd_oe_q  <= cap_oe_q;
    end
  end

  assign sdo_o      = cap_out_q;
  assign core_in_o  = pad_in_i;
  assign pad_out_o  = use_upd_i ? upd_out_q : core_out_i;
  assign pad_oe_n_o = force_off_i ? 1'b1 : (use_upd_i ? upd_oe_q : core_oe_n_i);

  p_shift_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shf_en_i |=> (cap_in_q == $past(sdi_i)) && (cap_oe_q == $past(cap_in_q))
                 && (cap_out_q == $past(cap_oe_q)));
  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !shf_en_i) |=> (cap_out_q == $past(core_out_i))
                 && (cap_oe_q == $past(core_oe_n_i)) && (cap_in_q == $past(pad_in_i)));
  p_update_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> (upd_out_q == $past(cap_out_q)) && (upd_oe_q == $past(cap_oe_q)));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && !shf_en_i && !upd_en_i) |=>
      $stable({cap_in_q, cap_oe_q, cap_out_q, upd_out_q, upd_oe_q}));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clock_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic [1:0]        mode_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [N_PINS-1:0] core_out_i,
  input  logic [N_PINS-1:0] core_oe_n_i,
  output logic [N_PINS-1:0] core_in_o,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_n_o,
  input  logic [N_PINS-1:0] pad_in_i
);
  localparam int ChainLen = 3 * N_PINS;

  bscan_mode_e mode;
  logic cap_en, shf_en, upd_en, use_upd, force_off;
  logic [N_PINS:0] ser;

  assign mode = bscan_mode_e'(mode_i);

  bscan_ctl u_ctl (
    .mode_i      (mode),
    .clock_i     (clock_i),
    .shift_i     (shift_i),
    .update_i    (update_i),
    .cap_en_o    (cap_en),
    .shf_en_o    (shf_en),
    .upd_en_o    (upd_en),
    .use_upd_o   (use_upd),
    .force_off_o (force_off)
  );

  assign ser[0] = sdi_i;

  for (genvar i = 0; i < N_PINS; i++) begin : g_cell
    bscan_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cap_en_i    (cap_en),
      .shf_en_i    (shf_en),
      .upd_en_i    (upd_en),
      .use_upd_i   (use_upd),
      .force_off_i (force_off),
      .sdi_i       (ser[i]),
      .sdo_o       (ser[i+1]),
      .core_out_i  (core_out_i[i]),
      .core_oe_n_i (core_oe_n_i[i]),
      .core_in_o   (core_in_o[i]),
      .pad_out_o   (pad_out_o[i]),
      .pad_oe_n_o  (pad_oe_n_o[i]),
      .pad_in_i    (pad_in_i[i])
    );
  end

  assign sdo_o = ser[N_PINS];

  initial assert (ChainLen == 3 * N_PINS && N_PINS > 0);

  p_highz_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (&pad_oe_n_o));
  p_sample_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (pad_out_o == core_out_i) && (pad_oe_n_o == core_oe_n_i));
  p_core_in_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_in_o == pad_in_i);
  p_clamp_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'b10) && $past(mode_i == 2'b10)) |-> $stable(pad_out_o) && $stable(pad_oe_n_o));
endmodule

// File: tb/bscan_chain_test.sv
module bscan_chain_test;
  localparam int N = 8;
  localparam int LEN = 3 * N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clock, shift, update, sdi, sdo;
  logic [1:0] mode;
  logic [N-1:0] core_out, core_oe_n, core_in, pad_out, pad_oe_n, pad_in;

  int total = 0;
  int bad = 0;

  bit mq[$];
  logic [N-1:0] m_uo, m_uoe;

  bscan_chain #(.N_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clock_i(clock), .shift_i(shift),
    .update_i(update), .mode_i(mode), .sdi_i(sdi), .sdo_o(sdo),
    .core_out_i(core_out), .core_oe_n_i(core_oe_n), .core_in_o(core_in),
    .pad_out_o(pad_out), .pad_oe_n_o(pad_oe_n), .pad_in_i(pad_in)
  );

  task automatic model_reset();
    mq.delete();
    for (int k = 0; k < LEN; k++) mq.push_back(1'b0);
    m_uo  = '0;
    m_uoe = '1;
  endtask

  // reference model: update reads pre-edge chain, then capture or shift
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else if (mode < 2) begin
      if (update)
        for (int i = 0; i < N; i++) begin
          m_uo[i]  = mq[3*i+2];
          m_uoe[i] = mq[3*i+1];
        end
      if (clock && shift) begin
        mq.push_front(sdi);
        void'(mq.pop_back());
      end else if (clock)
        for (int i = 0; i < N; i++) begin
          mq[3*i]   = pad_in[i];
          mq[3*i+1] = core_oe_n[i];
          mq[3*i+2] = core_out[i];
        end
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h mode=%0d t=%0t", tag, act, exp, mode, $time);
    end
  endtask

  task automatic compare();
    logic [N-1:0] e_out, e_oe;
    e_out = (mode == 2'b00) ? core_out : m_uo;
    e_oe  = (mode == 2'b00) ? core_oe_n : (mode == 2'b11) ? '1 : m_uoe;
    chk("R4 sdo", {{(N-1){1'b0}}, sdo}, {{(N-1){1'b0}}, mq[LEN-1]});
    case (mode)
      2'b00: begin chk("R2 pad_out", pad_out, e_out); chk("R2 pad_oe_n", pad_oe_n, e_oe); end
      2'b01: begin chk("R6 pad_out", pad_out, e_out); chk("R7 pad_oe_n", pad_oe_n, e_oe); end
      2'b10: begin chk("R9 pad_out", pad_out, e_out); chk("R9 pad_oe_n", pad_oe_n, e_oe); end
      default: chk("R8 pad_oe_n", pad_oe_n, e_oe);
    endcase
    chk("R11 core_in", core_in, pad_in);
  endtask

  task automatic step(logic [1:0] m, logic c, logic s, logic u, logic d);
    @(negedge clk);
    mode = m; clock = c; shift = s; update = u; sdi = d;
    core_out = N'($urandom); core_oe_n = N'($urandom); pad_in = N'($urandom);
    #1 compare();
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b01; clock = 0; shift = 0; update = 0; sdi = 0;
    core_out = '1; core_oe_n = '0; pad_in = '1;
    model_reset();
    #9;
    // R1: extest view of reset state: pads released, value 0, chain zero
    chk("R1 pad_oe_n", pad_oe_n, '1);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 sdo", {{(N-1){1'b0}}, sdo}, '0);
    rst_n = 1'b1;

    // R3 capture, R4 shift out and a full pass-through, R5 update
    step(2'b00, 1, 0, 0, 0);
    for (int k = 0; k < 2 * LEN + 3; k++) step(2'b00, 1, 1, 0, k[0] ^ k[2]);
    step(2'b00, 0, 0, 1, 0);
    // R6 and R7: extest drives from update flops, capture responses
    step(2'b01, 0, 0, 0, 0);
    step(2'b01, 1, 0, 0, 0);
    for (int k = 0; k < LEN; k++) step(2'b01, 1, 1, 0, k[1]);
    step(2'b01, 0, 0, 1, 0);
    // R9 and R10: clamp with strobes active must leave state untouched
    for (int k = 0; k < 20; k++) step(2'b10, k[0], k[1], k[2], k[0]);
    // R8 and R10: high-impedance with strobes active
    for (int k = 0; k < 20; k++) step(2'b11, k[1], k[0], 1, k[1]);
    // R10: shift state out in sample mode and check against model
    step(2'b01, 0, 0, 0, 0);
    for (int k = 0; k < LEN + 2; k++) step(2'b00, 1, 1, 0, 1);

    // random mix
    for (int k = 0; k < 4000; k++)
      step(2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) == 0, 1'($urandom));

    // asynchronous reset mid-run, R1
    @(negedge clk); rst_n = 1'b0; #1;
    mode = 2'b01;
    #0 chk("R1 reset mid-run oe", pad_oe_n, '1);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < LEN; k++) step(2'b00, 1, 1, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule